// File: doc/BRIEF.md
# PC-Compatible Programmable Serial UART

This block is one asynchronous serial channel behind the classic eight-register PC layout. A host reads and writes it over a byte-wide bus using a 3-bit address and separate read and write strobes. The block turns bytes written by the host into serial frames. It turns received frames back into bytes, and it keeps flags that describe the line and the modem wires. Start, parity and stop bits are added on transmit and removed on receive. A 16-bit divisor, reached through a bank-select bit in the line-format register, sets how many clock cycles make up one sample tick. Every bit lasts sixteen ticks.

Four interrupt causes can each be enabled on their own: line errors, received data, transmit register empty and modem-status change. They are combined onto a single request line. An identification register reports the most urgent pending cause. Software handles that cause, and handling it clears that cause. Read data comes back registered, one cycle after the read strobe. The clock input itself is the divisor reference.

Top module: `pc_uart`

## Requirements
- R1: With the bank-select bit (line-format bit 7) set, addresses 0 and 1 read and write the low and high divisor bytes, and writes there reach neither the transmit register nor the interrupt enables. One bit lasts 16 × divisor clock cycles.
- R2: A frame is a low start bit, then 5 to 8 data bits least significant first (line-format bits 1:0 = length − 5), then an optional parity bit, then a high stop bit. A frame sent out and looped back returns the same data with no error flags.
- R3: Line-format bit 3 enables parity and bit 4 selects even (1) or odd (0). The transmitter generates the parity bit. A received parity mismatch sets line-status bit 2.
- R4: Line-format bit 2 selects one stop bit (0) or a long stop (1). The long stop is 1.5 bits for 5-bit characters and 2 bits otherwise. Back-to-back frames start 16·(1+data+parity)+stop_ticks+1 ticks apart.
- R5: After reset, the serial output is high, the interrupt request is low, both modem outputs are inactive high, line status reads 0x60 and identification reads 0x01.
- R6: The receiver samples at mid-bit. A low pulse that has ended before the middle of the start bit does not produce a character.
- R7: A stop bit that reads low sets framing error (line-status bit 3). An all-low frame also sets break (bit 4) and delivers 0x00.
- R8: Data ready (bit 0) sets on each received character and clears when address 0 is read. A character that arrives while data ready is set overwrites the held byte and sets overrun (bit 1). Reading line status (address 5) clears bits 1 to 4.
- R9: Bit 5 shows that the transmit register is empty. Bit 6 shows that the transmit register and the shifter are both idle. A written byte moves to the shifter as soon as the shifter is free.
- R10: Enable bits 0 to 3 at address 1 enable received data, transmit empty, line error and modem change. Identification (address 2) reports 0x06, 0x04, 0x02 or 0x00 in that priority order, or 0x01 when nothing is pending. Reading 0x02 clears the transmit-empty cause. The request line is high exactly when some enabled cause is pending.
- R11: Modem status (address 6) holds change flags in bits 0 to 3 (clear-to-send, data-set-ready, ring trailing edge, carrier) and the inverted input levels in bits 4 to 7 in the same order. Reading it clears the change flags. Control bits 0 and 1 at address 4 drive the ready and request outputs low.
- R12: Line-format bit 6 forces the serial output low while it is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock and divisor reference |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| rdata | output | 8 | Read data, valid the cycle after rd_en |
| ser_out | output | 1 | Serial transmit line |
| ser_in | input | 1 | Serial receive line |
| cts_n | input | 1 | Clear to send, active low |
| dsr_n | input | 1 | Data set ready, active low |
| ri_n | input | 1 | Ring indicator, active low |
| dcd_n | input | 1 | Carrier detect, active low |
| rts_n | output | 1 | Request to send, active low |
| dtr_n | output | 1 | Terminal ready, active low |
| irq | output | 1 | Interrupt request |

## Verification
The hardest state to reach is the one where all four interrupt causes are pending together. The identification priority can only be seen by clearing the causes one at a time. The bench builds this state by sending two frames without reading (overrun plus data ready), pulling clear-to-send low, and enabling the transmit-empty cause while the register is empty. It then walks the identification register down through each code. Error frames (bad parity, low stop, all-low break, short glitch) are driven directly onto the receive line with the loopback open. The format sweep uses a loop from ser_out back to ser_in.

// File: rtl/pc_uart_pkg.sv
package pc_uart_pkg;
  localparam int DIV_W = 16;

  typedef enum logic [2:0] {TX_IDLE, TX_START, TX_DATA, TX_PAR, TX_STOP} tx_state_t;
  typedef enum logic [2:0] {RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP, RX_WAIT} rx_state_t;

  typedef struct packed {
    logic       dlab;
    logic       brk;
    logic       stick;
    logic       even;
    logic       pen;
    logic       stop_long;
    logic [1:0] wlen;
  } line_cfg_t;

  localparam logic [3:0] IIR_NONE = 4'h1;
  localparam logic [3:0] IIR_LS   = 4'h6;
  localparam logic [3:0] IIR_RX   = 4'h4;
  localparam logic [3:0] IIR_TX   = 4'h2;
  localparam logic [3:0] IIR_MS   = 4'h0;

  function automatic logic [3:0] data_bits(input logic [1:0] w);
    return 4'd5 + {2'b00, w};
  endfunction

  function automatic logic [7:0] data_mask(input logic [1:0] w);
    return 8'hFF >> (3'd3 - {1'b0, w});
  endfunction
endpackage

// File: rtl/pc_uart_baud.sv
module pc_uart_baud
  import pc_uart_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt == '0) begin
      tick <= 1'b1;
      cnt  <= div - 1'b1;
    end else begin
      tick <= 1'b0;
      cnt  <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/pc_uart_tx.sv
module pc_uart_tx
  import pc_uart_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      tick,
  input  logic      load,
  input  logic [7:0] din,
  input  line_cfg_t cfg,
  output logic      so,
  output logic      busy
);
  tx_state_t  st;
  logic [7:0] sh;
  logic [4:0] cnt;
  logic [3:0] bitn;
  logic       par;
  logic [4:0] last;
  logic [3:0] nbits;
  logic [7:0] masked;

  assign nbits  = data_bits(cfg.wlen);
  assign masked = din & data_mask(cfg.wlen);
  assign busy   = (st != TX_IDLE);

  always_comb begin
    last = 5'd15;
    if (st == TX_STOP && cfg.stop_long)
      last = (cfg.wlen == 2'd0) ? 5'd23 : 5'd31;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= TX_IDLE; so <= 1'b1; sh <= '0; cnt <= '0; bitn <= '0; par <= 1'b0;
    end else if (st == TX_IDLE) begin
      if (load) begin
        st   <= TX_START;
        so   <= 1'b0;
        sh   <= masked;
        cnt  <= '0;
        par  <= cfg.even ? ^masked : ~^masked;
      end
    end else if (tick) begin
      if (cnt == last) begin
        cnt <= '0;
        case (st)
          TX_START: begin
            st <= TX_DATA; so <= sh[0]; sh <= sh >> 1; bitn <= 4'd1;
          end
          TX_DATA: begin
            if (bitn == nbits) begin
              st <= cfg.pen ? TX_PAR : TX_STOP;
              so <= cfg.pen ? par : 1'b1;
            end else begin
              so <= sh[0]; sh <= sh >> 1; bitn <= bitn + 4'd1;
            end
          end
          TX_PAR:  begin st <= TX_STOP; so <= 1'b1; end
          default: begin st <= TX_IDLE; so <= 1'b1; end
        endcase
      end else begin
        cnt <= cnt + 5'd1;
      end
    end
  end
endmodule

// File: rtl/pc_uart_rx.sv
module pc_uart_rx
  import pc_uart_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       rxd,
  input  line_cfg_t  cfg,
  output logic       done,
  output logic [7:0] dout,
  output logic       pe,
  output logic       fe,
  output logic       brk
);
  rx_state_t  st;
  logic [3:0] cnt;
  logic [3:0] bitn;
  logic [7:0] sh;
  logic       pbit;
  logic [7:0] aligned;
  logic       exp_par;

  assign aligned = sh >> (3'd3 - {1'b0, cfg.wlen});
  assign exp_par = cfg.even ? ^aligned : ~^aligned;

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= RX_IDLE; cnt <= '0; bitn <= '0; sh <= '0; pbit <= 1'b0;
      done <= 1'b0; dout <= '0; pe <= 1'b0; fe <= 1'b0; brk <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        RX_IDLE: if (!rxd) begin st <= RX_START; cnt <= '0; end
        RX_WAIT: if (rxd) st <= RX_IDLE;
        RX_START: if (tick) begin
          if (cnt == 4'd7) begin
            cnt <= '0; bitn <= '0; sh <= '0;
            st  <= rxd ? RX_IDLE : RX_DATA;
          end else cnt <= cnt + 4'd1;
        end
        default: if (tick) begin
          if (cnt == 4'd15) begin
            cnt <= '0;
            if (st == RX_DATA) begin
              sh   <= {rxd, sh[7:1]};
              bitn <= bitn + 4'd1;
              if (bitn == data_bits(cfg.wlen) - 4'd1)
                st <= cfg.pen ? RX_PAR : RX_STOP;
            end else if (st == RX_PAR) begin
              pbit <= rxd;
              st   <= RX_STOP;
            end else begin
              done <= 1'b1;
              dout <= aligned;
              pe   <= cfg.pen && (pbit != exp_par);
              fe   <= !rxd;
              brk  <= !rxd && (aligned == 8'h00) && !(cfg.pen && pbit);
              st   <= rxd ? RX_IDLE : RX_WAIT;
            end
          end else cnt <= cnt + 4'd1;
        end
      endcase
    end
  end
endmodule

// File: rtl/pc_uart.sv
module pc_uart
  import pc_uart_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] addr,
  input  logic [7:0] wdata,
  input  logic       wr_en,
  input  logic       rd_en,
  output logic [7:0] rdata,
  output logic       ser_out,
  input  logic       ser_in,
  input  logic       cts_n,
  input  logic       dsr_n,
  input  logic       ri_n,
  input  logic       dcd_n,
  output logic       rts_n,
  output logic       dtr_n,
  output logic       irq
);
  localparam int LAST = SYNC_STAGES - 1;

  line_cfg_t        lcr;
  logic [DIV_W-1:0] divisor;
  logic [7:0]       thr, rbr;
  logic             thr_full, thre_pend;
  logic [3:0]       ier;
  logic [1:0]       mcr;
  logic             lsr_dr, lsr_oe, lsr_pe, lsr_fe, lsr_bi;
  logic [3:0]       delta, m_prev, mst, dset;
  logic [3:0]       iir_code;
  logic [7:0]       rd_mux;
  logic             tick, tx_so, tx_busy, tx_load, brk_on;
  logic             rx_done, rx_pe, rx_fe, rx_bi;
  logic [7:0]       rx_data;
  logic [LAST:0]    rx_sync;
  logic [3:0]       m_sync [SYNC_STAGES];
  logic             int_ls, int_rx, int_tx, int_ms, msr_rd;

  // input synchronizers
  always_ff @(posedge clk) begin
    if (rst) rx_sync <= '1;
    else     rx_sync <= {rx_sync[LAST-1:0], ser_in};
  end

  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_msync
    always_ff @(posedge clk) begin
      if (rst)         m_sync[g] <= 4'hF;
      else if (g == 0) m_sync[g] <= {dcd_n, ri_n, dsr_n, cts_n};
      else             m_sync[g] <= m_sync[(g == 0) ? 0 : g - 1];
    end
  end

  assign mst  = ~m_sync[LAST];  // {dcd, ri, dsr, cts}
  assign dset = {mst[3] ^ m_prev[3], m_prev[2] & ~mst[2],
                 mst[1] ^ m_prev[1], mst[0] ^ m_prev[0]};

  pc_uart_baud u_baud (.clk(clk), .rst(rst), .div(divisor), .tick(tick));

  assign tx_load = thr_full && !tx_busy;
  assign brk_on  = lcr.brk;

  pc_uart_tx u_tx (.clk(clk), .rst(rst), .tick(tick), .load(tx_load), .din(thr),
                   .cfg(lcr), .so(tx_so), .busy(tx_busy));

  pc_uart_rx u_rx (.clk(clk), .rst(rst), .tick(tick), .rxd(rx_sync[LAST]), .cfg(lcr),
                   .done(rx_done), .dout(rx_data), .pe(rx_pe), .fe(rx_fe), .brk(rx_bi));

  // interrupt identification, fixed priority
  assign int_ls = ier[2] && (lsr_oe || lsr_pe || lsr_fe || lsr_bi);
  assign int_rx = ier[0] && lsr_dr;
  assign int_tx = ier[1] && thre_pend;
  assign int_ms = ier[3] && (delta != 4'h0);

  always_comb begin
    if      (int_ls) iir_code = IIR_LS;
    else if (int_rx) iir_code = IIR_RX;
    else if (int_tx) iir_code = IIR_TX;
    else if (int_ms) iir_code = IIR_MS;
    else             iir_code = IIR_NONE;
  end

  always_comb begin
    case (addr)
      3'd0:    rd_mux = lcr.dlab ? divisor[7:0] : rbr;
      3'd1:    rd_mux = lcr.dlab ? divisor[15:8] : {4'h0, ier};
      3'd2:    rd_mux = {4'h0, iir_code};
      3'd3:    rd_mux = lcr;
      3'd4:    rd_mux = {6'h0, mcr};
      3'd5:    rd_mux = {1'b0, !thr_full && !tx_busy, !thr_full,
                         lsr_bi, lsr_fe, lsr_pe, lsr_oe, lsr_dr};
      3'd6:    rd_mux = {mst, delta};
      default: rd_mux = 8'h00;
    endcase
  end

  assign msr_rd = rd_en && (addr == 3'd6);
  assign rts_n  = ~mcr[1];
  assign dtr_n  = ~mcr[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      lcr <= '0; divisor <= 16'd1; thr <= '0; rbr <= '0;
      thr_full <= 1'b0; thre_pend <= 1'b0; ier <= '0; mcr <= '0;
      {lsr_dr, lsr_oe, lsr_pe, lsr_fe, lsr_bi} <= '0;
      delta <= '0; m_prev <= '0; rdata <= '0; irq <= 1'b0; ser_out <= 1'b1;
    end else begin
      ser_out <= tx_so & ~lcr.brk;
      irq     <= int_ls || int_rx || int_tx || int_ms;
      m_prev  <= mst;
      delta   <= (msr_rd ? 4'h0 : delta) | dset;
      if (tx_load) begin
        thr_full  <= 1'b0;
        thre_pend <= 1'b1;
      end
      if (rd_en) begin
        rdata <= rd_mux;
        case (addr)
          3'd0: if (!lcr.dlab) lsr_dr <= 1'b0;
          3'd2: if (iir_code == IIR_TX) thre_pend <= 1'b0;
          3'd5: {lsr_oe, lsr_pe, lsr_fe, lsr_bi} <= '0;
          default: ;
        endcase
      end
      if (wr_en) begin
        case (addr)
          3'd0: if (lcr.dlab) divisor[7:0] <= wdata;
                else begin thr <= wdata; thr_full <= 1'b1; thre_pend <= 1'b0; end
          3'd1: if (lcr.dlab) divisor[15:8] <= wdata;
                else begin
                  ier <= wdata[3:0];
                  if (wdata[1] && !thr_full) thre_pend <= 1'b1;
                end
          3'd3: lcr <= wdata;
          3'd4: mcr <= wdata[1:0];
          default: ;
        endcase
      end
      if (rx_done) begin
        rbr    <= rx_data;
        lsr_dr <= 1'b1;
        if (lsr_dr) lsr_oe <= 1'b1;
        if (rx_pe)  lsr_pe <= 1'b1;
        if (rx_fe)  lsr_fe <= 1'b1;
        if (rx_bi)  lsr_bi <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/pc_uart_chk.sv
module pc_uart_chk (
  input logic       clk,
  input logic       rst,
  input logic       irq,
  input logic [3:0] ier,
  input logic       rx_done,
  input logic       dr,
  input logic       oe,
  input logic       thr_full,
  input logic       tx_busy,
  input logic       brk,
  input logic       ser_out
);
  assert_idle_mark_R5: assert property (@(posedge clk) disable iff (rst)
    $past(!tx_busy && !brk) |-> ser_out);

  assert_irq_enabled_R10: assert property (@(posedge clk) disable iff (rst)
    irq |-> ($past(ier) != 4'h0));

  assert_dr_source_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(dr) |-> $past(rx_done));

  assert_overrun_source_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(oe) |-> $past(rx_done && dr));

  assert_handoff_R9: assert property (@(posedge clk) disable iff (rst)
    (thr_full && !tx_busy) |=> tx_busy);
endmodule

bind pc_uart pc_uart_chk u_chk (
  .clk(clk), .rst(rst), .irq(irq), .ier(ier), .rx_done(rx_done), .dr(lsr_dr),
  .oe(lsr_oe), .thr_full(thr_full), .tx_busy(tx_busy), .brk(brk_on), .ser_out(ser_out)
);

// File: tb/tb_pc_uart.sv
module tb_pc_uart;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] rdata;
  logic       ser_out, ser_in;
  logic       cts_n = 1'b1, dsr_n = 1'b1, ri_n = 1'b1, dcd_n = 1'b1;
  logic       rts_n, dtr_n, irq;
  logic       lp = 1'b0, rx_drv = 1'b1;

  int errors = 0, checks = 0;
  int cyc = 0, nfalls = 0;
  int fall_t [16];
  logic prev_so = 1'b1;
  bit done_flag = 0;

  always #5 clk = ~clk;
  assign ser_in = lp ? ser_out : rx_drv;

  pc_uart dut (.clk(clk), .rst(rst), .addr(addr), .wdata(wdata), .wr_en(wr_en),
               .rd_en(rd_en), .rdata(rdata), .ser_out(ser_out), .ser_in(ser_in),
               .cts_n(cts_n), .dsr_n(dsr_n), .ri_n(ri_n), .dcd_n(dcd_n),
               .rts_n(rts_n), .dtr_n(dtr_n), .irq(irq));

  always @(posedge clk) begin
    cyc <= cyc + 1;
    prev_so <= ser_out;
    if (prev_so && !ser_out && nfalls < 16) begin
      fall_t[nfalls] <= cyc;
      nfalls <= nfalls + 1;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_temt();
    logic [7:0] v;
    for (int i = 0; i < 3000; i++) begin
      rd(3'd5, v);
      if (v[6]) break;
    end
  endtask

  task automatic send_frame(input logic [7:0] d, input int n, input bit pen, input bit even,
                            input bit flip, input bit stopv, input int bc);
    logic p;
    p = even ? ^(d & (8'hFF >> (8 - n))) : ~^(d & (8'hFF >> (8 - n)));
    rx_drv = 1'b0; idle(bc);
    for (int i = 0; i < n; i++) begin rx_drv = d[i]; idle(bc); end
    if (pen) begin rx_drv = p ^ flip; idle(bc); end
    rx_drv = stopv; idle(bc);
    rx_drv = 1'b1; idle(2 * bc);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done_flag) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] v, lcrv, d;
    int n, exp;
    idle(4); rst = 1'b0; idle(2);

    // R5 reset state
    chk("R5 ser_out", ser_out, 1); chk("R5 irq", irq, 0);
    chk("R5 rts_n", rts_n, 1);     chk("R5 dtr_n", dtr_n, 1);
    rd(3'd5, v); chk("R5 lsr", v, 8'h60);
    rd(3'd2, v); chk("R5 iir", v, 8'h01);

    // R1 bank select: divisor writes do not start a transmission
    wr(3'd3, 8'h83); wr(3'd0, 8'h01); wr(3'd1, 8'h00);
    rd(3'd0, v); chk("R1 div lo readback", v, 8'h01);
    wr(3'd3, 8'h03); rd(3'd5, v); chk("R1 no thr write", v, 8'h60);
    chk("R1 line idle", ser_out, 1);

    // R2 R3 loopback sweep over length, parity and stop
    lp = 1'b1;
    for (int wl = 0; wl < 4; wl++)
      for (int pm = 0; pm < 3; pm++)
        for (int st = 0; st < 2; st++)
          for (int k = 0; k < 3; k++) begin
            n = 5 + wl;
            lcrv = 8'(wl | (st << 2) | ((pm != 0) << 3) | ((pm == 2) << 4));
            d = (k == 0) ? 8'h00 : (k == 1) ? 8'hFF : 8'(8'h96 ^ (wl * 16 + pm * 4 + st));
            d = d & 8'(8'hFF >> (8 - n));
            wr(3'd3, lcrv); wr(3'd0, d);
            v = 8'h00;
            for (int i = 0; i < 2000; i++) begin rd(3'd5, v); if (v[0]) break; end
            chk("R2 R3 no errors", v[4:0], 5'b00001);
            rd(3'd0, v); chk("R2 loopback data", v, d);
            wait_temt();
          end
    lp = 1'b0;

    // R4 stop length: back-to-back frame spacing, data all ones
    for (int wl = 0; wl < 4; wl++)
      for (int st = 0; st < 2; st++) begin
        wr(3'd3, 8'(wl | (st << 2)));
        nfalls = 0;
        wr(3'd0, 8'hFF); idle(3); wr(3'd0, 8'hFF);
        wait_temt(); idle(2);
        exp = 16 * (6 + wl) + (st == 0 ? 16 : (wl == 0 ? 24 : 32)) + 1;
        chk("R4 frame period", fall_t[1] - fall_t[0], exp);
      end

    // R1 divisor 2: two bit periods = 64 cycles
    wr(3'd3, 8'h83); wr(3'd0, 8'h02); wr(3'd3, 8'h03);
    nfalls = 0; wr(3'd0, 8'h55); wait_temt(); idle(2);
    chk("R1 bit time div2", fall_t[2] - fall_t[1], 64);
    wr(3'd3, 8'h83); wr(3'd0, 8'h01); wr(3'd3, 8'h03);

    // R3 parity error, even parity 8 bits
    wr(3'd3, 8'h1B);
    send_frame(8'h01, 8, 1, 1, 1, 1, 16);
    rd(3'd5, v); chk("R3 parity error", v, 8'h65);
    rd(3'd5, v); chk("R8 lsr read clears errors", v, 8'h61);
    rd(3'd0, v); chk("R3 data", v, 8'h01);

    // R7 framing error
    wr(3'd3, 8'h03);
    send_frame(8'h5A, 8, 0, 0, 0, 0, 16);
    rd(3'd5, v); chk("R7 framing", v, 8'h69);
    rd(3'd0, v); chk("R7 framing data", v, 8'h5A);

    // R7 break
    rx_drv = 1'b0; idle(16 * 12); rx_drv = 1'b1; idle(64);
    rd(3'd5, v); chk("R7 break", v, 8'h79);
    rd(3'd0, v); chk("R7 break data", v, 8'h00);
    rd(3'd5, v); chk("R8 dr cleared", v, 8'h60);

    // R8 overrun
    send_frame(8'h11, 8, 0, 0, 0, 1, 16);
    send_frame(8'h22, 8, 0, 0, 0, 1, 16);
    rd(3'd5, v); chk("R8 overrun", v, 8'h63);
    rd(3'd0, v); chk("R8 overwritten data", v, 8'h22);

    // R6 glitch rejected
    rx_drv = 1'b0; idle(5); rx_drv = 1'b1; idle(400);
    rd(3'd5, v); chk("R6 glitch ignored", v, 8'h60);

    // R9 register empty and shifter busy
    wr(3'd0, 8'hC3); idle(2);
    rd(3'd5, v); chk("R9 thre set temt clear", v[6:5], 2'b01);
    wait_temt(); rd(3'd5, v); chk("R9 temt", v[6:5], 2'b11);

    // R11 modem status and control
    wr(3'd4, 8'h03); idle(1);
    chk("R11 dtr_n", dtr_n, 0); chk("R11 rts_n", rts_n, 0);
    rd(3'd6, v);
    dsr_n = 1'b0; idle(5); rd(3'd6, v); chk("R11 dsr change", v, 8'h22);
    ri_n = 1'b0;  idle(5); rd(3'd6, v); chk("R11 ring on", v, 8'h60);
    ri_n = 1'b1;  idle(5); rd(3'd6, v); chk("R11 ring trailing", v, 8'h24);
    dsr_n = 1'b1; idle(5); rd(3'd6, v); chk("R11 dsr off", v, 8'h02);
    rd(3'd6, v); chk("R11 deltas cleared", v, 8'h00);

    // R10 interrupt priority
    send_frame(8'h33, 8, 0, 0, 0, 1, 16);
    send_frame(8'h44, 8, 0, 0, 0, 1, 16);
    cts_n = 1'b0; idle(5);
    chk("R10 disabled irq", irq, 0);
    rd(3'd2, v); chk("R10 none enabled", v, 8'h01);
    wr(3'd1, 8'h0F); idle(2);
    chk("R10 irq raised", irq, 1);
    rd(3'd2, v); chk("R10 line status first", v, 8'h06);
    rd(3'd5, v);
    rd(3'd2, v); chk("R10 rx data second", v, 8'h04);
    rd(3'd0, v);
    rd(3'd2, v); chk("R10 tx empty third", v, 8'h02);
    rd(3'd2, v); chk("R10 modem last", v, 8'h00);
    rd(3'd6, v); chk("R11 cts change", v, 8'h11);
    rd(3'd2, v); chk("R10 all cleared", v, 8'h01);
    idle(2); chk("R10 irq dropped", irq, 0);
    wr(3'd1, 8'h00);

    // R12 break control
    wr(3'd3, 8'h43); idle(2); chk("R12 forced low", ser_out, 0);
    wr(3'd3, 8'h03); idle(2); chk("R12 released", ser_out, 1);

    done_flag = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule